// File: doc/BRIEF.md
# Register Window Spill/Fill Manager

This block keeps the current window pointer of a circular register-window file. It also keeps a mask that marks which windows are invalid. A save moves the pointer one window down, and a restore moves it one window up, both modulo the window count. Before either move, the block checks the mask bit of the destination window.

If the destination window is valid, the pointer moves on the next clock edge. If it is invalid, what happens depends on the mode input sampled with the strobe:

- **Trap mode:** the block issues a one-cycle overflow request (for a save) or underflow request (for a restore) and leaves its state untouched.
- **Self-servicing mode:** the block asks an external memory engine to move one window and raises `busy_o` until the engine acknowledges. A save spills the window two below the current one; a restore fills the window just above it. On the acknowledge cycle the mask rotates one place and the stalled move completes.

The block produces only window indices and handshakes; it never moves register contents.

Top module: `regwin_mgr`

## Requirements
- R1: After reset, `cwp_o` is 0, `wim_o` equals the parameter `WIM_INIT`, and `busy_o`, `ovf_trap_o` and `unf_trap_o` are all 0.
- R2: A save whose destination window (cwp-1, wrapping 0 to NWIN-1) has a clear mask bit sets `cwp_o` to that destination on the next edge.
- R3: A restore whose destination window (cwp+1, wrapping NWIN-1 to 0) has a clear mask bit sets `cwp_o` to that destination on the next edge.
- R4: In trap mode (`svc_mode_i`=0), a save into an invalid window pulses `ovf_trap_o` for one cycle after the strobe edge, and leaves `cwp_o` and `wim_o` unchanged.
- R5: In trap mode, a restore into an invalid window pulses `unf_trap_o` for one cycle, and leaves `cwp_o` and `wim_o` unchanged.
- R6: In self-servicing mode (`svc_mode_i`=1), a save into an invalid window raises `busy_o` with `xfer_dir_o`=0 (spill) and `xfer_win_o`=cwp-2 mod NWIN. These outputs hold until `xfer_ack_i`.
- R7: On a spill acknowledge, the mask rotates right by one within NWIN bits (new[i]=old[(i+1) mod NWIN]), `cwp_o` steps down by one, and `busy_o` falls.
- R8: In self-servicing mode, a restore into an invalid window raises `busy_o` with `xfer_dir_o`=1 (fill) and `xfer_win_o`=cwp+1 mod NWIN.
- R9: On a fill acknowledge, the mask rotates left by one (new[i]=old[(i-1) mod NWIN]), `cwp_o` steps up by one, and `busy_o` falls.
- R10: Save and restore strobes have no effect while `busy_o` is 1. `xfer_ack_i` has no effect while `busy_o` is 0.
- R11: When save and restore are strobed in the same cycle, only the save is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_i | input | 1 | Save strobe |
| restore_i | input | 1 | Restore strobe |
| svc_mode_i | input | 1 | 1 = service invalid windows locally, 0 = raise trap requests |
| xfer_ack_i | input | 1 | Memory engine has finished the requested window move |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| wim_o | output | NWIN | Invalid-window mask |
| busy_o | output | 1 | Spill/fill request outstanding; strobes are ignored |
| xfer_dir_o | output | 1 | 0 = spill, 1 = fill |
| xfer_win_o | output | $clog2(NWIN) | Window index to spill or fill |
| ovf_trap_o | output | 1 | Window overflow trap request (one cycle) |
| unf_trap_o | output | 1 | Window underflow trap request (one cycle) |

## Verification
On every cycle, the embedded properties check three things:

- The number of invalid windows never changes.
- The trap requests and the busy flag never overlap.
- A pending request keeps its direction and index, and freezes pointer and mask until the acknowledge arrives; a spill acknowledge steps the pointer down and a fill acknowledge steps it up.

Only the bench's scenarios can show that the correct window is chosen, that the mask rotates in the correct direction, that wraparound works at both ends, and that the mode and save priority are respected. The bench shows this by comparing every output against a behavioural model each clock.

// File: rtl/regwin_mgr.sv
module regwin_mgr #(
  parameter int NWIN = 8,
  parameter logic [NWIN-1:0] WIM_INIT = 2,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic          svc_mode_i,
  input  logic          xfer_ack_i,
  output logic [CW-1:0] cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic          busy_o,
  output logic          xfer_dir_o,
  output logic [CW-1:0] xfer_win_o,
  output logic          ovf_trap_o,
  output logic          unf_trap_o
);

  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  function automatic logic [CW-1:0] wdec(input logic [CW-1:0] w);
    return (w == '0) ? TOP : w - 1'b1;
  endfunction

  function automatic logic [CW-1:0] winc(input logic [CW-1:0] w);
    return (w == TOP) ? '0 : w + 1'b1;
  endfunction

  logic [CW-1:0]   cwp_q, xwin_q;
  logic [NWIN-1:0] wim_q;
  logic            busy_q, dir_q, ovf_q, unf_q;

  wire [CW-1:0] save_dst = wdec(cwp_q);
  wire [CW-1:0] rest_dst = winc(cwp_q);
  wire          save_bad = wim_q[save_dst];
  wire          rest_bad = wim_q[rest_dst];
  wire          do_save  = !busy_q && save_i;
  wire          do_rest  = !busy_q && !save_i && restore_i;

  wire [NWIN-1:0] wim_rr = {wim_q[0], wim_q[NWIN-1:1]};
  wire [NWIN-1:0] wim_rl = {wim_q[NWIN-2:0], wim_q[NWIN-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      wim_q  <= WIM_INIT;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      xwin_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      if (busy_q) begin
        if (xfer_ack_i) begin
          busy_q <= 1'b0;
          if (dir_q) begin
            wim_q <= wim_rl;
            cwp_q <= rest_dst;
          end else begin
            wim_q <= wim_rr;
            cwp_q <= save_dst;
          end
        end
      end else if (do_save) begin
        if (!save_bad) cwp_q <= save_dst;
        else if (svc_mode_i) begin
          busy_q <= 1'b1;
          dir_q  <= 1'b0;
          xwin_q <= wdec(save_dst);
        end else ovf_q <= 1'b1;
      end else if (do_rest) begin
        if (!rest_bad) cwp_q <= rest_dst;
        else if (svc_mode_i) begin
          busy_q <= 1'b1;
          dir_q  <= 1'b1;
          xwin_q <= rest_dst;
        end else unf_q <= 1'b1;
      end
    end
  end

  assign cwp_o      = cwp_q;
  assign wim_o      = wim_q;
  assign busy_o     = busy_q;
  assign xfer_dir_o = dir_q;
  assign xfer_win_o = xwin_q;
  assign ovf_trap_o = ovf_q;
  assign unf_trap_o = unf_q;

  // R7, R9: rotation preserves the number of invalid windows
  a_r7_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(wim_o) == $past($countones(wim_o)));

  // R4, R5, R6: trap requests and a pending transfer are mutually exclusive
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap_o, unf_trap_o, busy_o}));

  // R4: a trap leaves pointer and mask untouched
  a_r4_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap_o || unf_trap_o) |-> $stable(cwp_o) && $stable(wim_o));

  // R10: strobes during a pending transfer change nothing
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_ack_i) |=> busy_o && $stable(cwp_o) && $stable(wim_o)
                               && $stable(xfer_win_o) && $stable(xfer_dir_o));

  // R7: spill ack steps the pointer down
  a_r7_spill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_dir_o && xfer_ack_i) |=> !busy_o &&
      (cwp_o == (($past(cwp_o) == '0) ? TOP : $past(cwp_o) - 1'b1)));

  // R9: fill ack steps the pointer up
  a_r9_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && xfer_dir_o && xfer_ack_i) |=> !busy_o &&
      (cwp_o == (($past(cwp_o) == TOP) ? '0 : $past(cwp_o) + 1'b1)));

endmodule

// File: tb/regwin_mgr_tb_top.sv
module regwin_mgr_tb_top;
  localparam int NWIN = 8;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic save_i = 0, restore_i = 0, svc_mode_i = 0, xfer_ack_i = 0;
  logic [CW-1:0] cwp_o, xfer_win_o;
  logic [NWIN-1:0] wim_o;
  logic busy_o, xfer_dir_o, ovf_trap_o, unf_trap_o;

  regwin_mgr #(.NWIN(NWIN), .WIM_INIT(8'h02)) dut_i (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_cwp, m_wim, m_busy, m_dir, m_win, m_ovf, m_unf;
  bit done = 0;

  function automatic int dn(int w); return (w + NWIN - 1) % NWIN; endfunction
  function automatic int up(int w); return (w + 1) % NWIN; endfunction

  task automatic chk(string tag, string fld, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "cwp", cwp_o, m_cwp);
    chk(tag, "wim", wim_o, m_wim);
    chk(tag, "busy", busy_o, m_busy);
    chk(tag, "ovf", ovf_trap_o, m_ovf);
    chk(tag, "unf", unf_trap_o, m_unf);
    if (m_busy) begin
      chk(tag, "dir", xfer_dir_o, m_dir);
      chk(tag, "win", xfer_win_o, m_win);
    end
  endtask

  task automatic model_step(bit s, bit r, bit m, bit a);
    int d;
    m_ovf = 0; m_unf = 0;
    if (m_busy) begin
      if (a) begin
        if (m_dir == 0) begin
          m_wim = ((m_wim >> 1) | ((m_wim & 1) << (NWIN-1))) & 'hff;
          m_cwp = dn(m_cwp);
        end else begin
          m_wim = ((m_wim << 1) | (m_wim >> (NWIN-1))) & 'hff;
          m_cwp = up(m_cwp);
        end
        m_busy = 0;
      end
    end else if (s) begin
      d = dn(m_cwp);
      if (((m_wim >> d) & 1) == 0) m_cwp = d;
      else if (m) begin m_busy = 1; m_dir = 0; m_win = dn(d); end
      else m_ovf = 1;
    end else if (r) begin
      d = up(m_cwp);
      if (((m_wim >> d) & 1) == 0) m_cwp = d;
      else if (m) begin m_busy = 1; m_dir = 1; m_win = d; end
      else m_unf = 1;
    end
  endtask

  task automatic cyc(string tag, bit s, bit r, bit m, bit a);
    save_i = s; restore_i = r; svc_mode_i = m; xfer_ack_i = a;
    @(posedge clk);
    model_step(s, r, m, a);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    m_cwp = 0; m_wim = 'h02; m_busy = 0; m_dir = 0; m_win = 0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    // trap mode underflow at window 1
    cyc("R5", 0, 1, 0, 0);
    cyc("R5", 0, 0, 0, 0);
    // saves wrap 0->7 and walk down to 2
    for (int i = 0; i < 6; i++) cyc("R2", 1, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0);
    cyc("R3", 0, 1, 0, 0);
    cyc("R2", 1, 0, 0, 0);
    // self-service spill with stalled strobes
    cyc("R6", 1, 0, 1, 0);
    cyc("R10", 1, 0, 1, 0);
    cyc("R10", 0, 1, 0, 0);
    cyc("R10", 1, 1, 1, 0);
    cyc("R7", 0, 0, 1, 1);
    cyc("R10", 0, 0, 1, 1);
    cyc("R3", 0, 1, 1, 0);
    cyc("R2", 1, 0, 1, 0);
    cyc("R6", 1, 0, 1, 0);
    cyc("R7", 0, 0, 1, 1);
    // walk up to 6 and fill window 7
    for (int i = 0; i < 6; i++) cyc("R3", 0, 1, 1, 0);
    cyc("R8", 0, 1, 1, 0);
    cyc("R10", 0, 1, 1, 0);
    cyc("R9", 0, 0, 1, 1);
    cyc("R11", 1, 1, 1, 0);
    cyc("R11", 1, 1, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      cyc("R10", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule